// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block drives the five shared LED/strap pads of a 10/100 Ethernet transceiver from its link, speed, duplex, activity and collision status. Each pad means two things. While reset is asserted the pad is an input, and its level sets a strap. After reset the pad is an LED output. The strap level read at reset sets the polarity of that pin and also becomes one bit of the PHY management address.

Two display layouts are available. The three-LED layout uses a speed lamp, a combined link/activity lamp and a combined duplex/collision lamp. The four-LED layout uses separate 100M-link and 10M-link lamps, an activity lamp and the same duplex/collision lamp. Blinks run at 10 Hz for activity and at 20 Hz for collision. Both rates come from counters whose length is derived from the `CLK_HZ` parameter. Each blink has a 50 % duty cycle and always begins with its on half.

Top module: `phy_led_ctrl`

## Requirements
- R1: On the first rising clock edge after `rst_ni` goes high, `strap_i` is captured. `phy_addr_o` then equals the captured value, with bit 4 as the address MSB, and stays fixed until the next reset whatever `strap_i` does.
- R2: `led_oe_o` is low while `rst_ni` is low, until the capture edge of R1, and whenever `pwr_down_i` is high. While `led_oe_o` is low, `led_o` is all zeros.
- R3: A pin whose captured strap bit is 0 drives 1 when lit and 0 when dark. A pin whose captured strap bit is 1 drives 0 when lit and 1 when dark.
- R4: When `led_mode_i`=0 (three-LED layout), pin 0 is lit exactly when `speed100_i` is high.
- R5: When `led_mode_i`=0, pin 2 shows the activity blink while an activity burst runs and otherwise is lit exactly when `link_ok_i` is high. In this layout the activity condition is (`rx_act_i` or `tx_act_i`) and not `col_i`.
- R6: Pin 1 is lit steadily while `full_dup_i` is high. In half duplex with `col_i` high, it blinks with a period of CLK_HZ/20 cycles, lit for the first half. It goes dark the cycle after `col_i` falls, and the next collision starts again on the lit half.
- R7: The activity blink has a period of CLK_HZ/10 cycles, lit for the first half. A burst starts on the edge after the condition appears. Once started, it runs whole periods while the condition holds, so a single-cycle pulse gives exactly one lit half followed by one dark half.
- R8: When `led_mode_i`=1 (four-LED layout), pin 0 is `link_ok_i & speed100_i`, pin 4 is `link_ok_i & ~speed100_i`, and pin 3 shows the activity blink. The activity condition is `rx_act_i | tx_act_i` regardless of `col_i`, and pin 2 stays dark.
- R9: When `led_mode_i`=0, pins 3 and 4 stay dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset; strap sampling window |
| led_mode_i | input | 1 | 0 = three-LED layout, 1 = four-LED layout |
| link_ok_i | input | 1 | Link is up |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup_i | input | 1 | Full duplex |
| rx_act_i | input | 1 | Receive activity |
| tx_act_i | input | 1 | Transmit activity |
| col_i | input | 1 | Collision present |
| pwr_down_i | input | 1 | Power-down; releases the pads |
| strap_i | input | 5 | Level read on the pads |
| led_o | output | 5 | LED drive levels |
| led_oe_o | output | 1 | Pad output enable |
| phy_addr_o | output | 5 | Captured PHY address |

## Verification
The bench goes after the strap capture edge. A design that captures one cycle late, or keeps following the pads, shows a wrong address or polarity. It drives single-cycle activity pulses and counts the lit cycles. An unstretched design shows a one-cycle flash instead of a full half period. It checks that a collision in the three-LED layout suppresses the activity blink and that full duplex masks the collision blink. It also restarts collisions mid-period. A blinker that resumes its old phase would come back on the dark half.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
  localparam int NPINS = 5;
  localparam int PIN_SPD    = 0;
  localparam int PIN_DUPCOL = 1;
  localparam int PIN_LNKACT = 2;
  localparam int PIN_ACT    = 3;
  localparam int PIN_TEN    = 4;

  typedef enum logic {
    MODE_TRIPLE = 1'b0,
    MODE_QUAD   = 1'b1
  } led_mode_e;
endpackage

// File: rtl/led_blinker.sv
module led_blinker #(
  parameter int PERIOD  = 2_500_000,
  parameter bit STRETCH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic busy_o,
  output logic lit_o
);
  localparam int HALF = PERIOD / 2;
  localparam int CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= cond_i;
      cnt_q <= '0;
    end else if (!STRETCH && !cond_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      run_q <= cond_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = run_q;
  assign lit_o  = run_q && (cnt_q < HALF_C);

  AST_BLINK_STARTS_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cond_i) |=> (busy_o && lit_o)); // R7
  AST_BURST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STRETCH && busy_o && cnt_q != LAST) |=> busy_o); // R7
  AST_NO_STRETCH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!STRETCH && !cond_i) |=> !busy_o); // R6
endmodule

// File: rtl/led_strap_latch.sv
module led_strap_latch #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strap_i,
  output logic         done_o,
  output logic [W-1:0] pol_o
);
  logic         done_q;
  logic [W-1:0] pol_q;

  // capture on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pol_q  <= '0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      pol_q  <= strap_i;
    end
  end

  assign done_o = done_q;
  assign pol_o  = pol_q;

  AST_POL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(pol_q)); // R1
endmodule

// File: rtl/led_pin_map.sv
module led_pin_map
  import phy_led_pkg::*;
(
  input  led_mode_e         mode_i,
  input  logic              link_ok_i,
  input  logic              speed100_i,
  input  logic              full_dup_i,
  input  logic              act_busy_i,
  input  logic              act_lit_i,
  input  logic              col_lit_i,
  output logic [NPINS-1:0]  on_o
);
  always_comb begin
    on_o             = '0;
    on_o[PIN_DUPCOL] = full_dup_i | col_lit_i;
    if (mode_i == MODE_TRIPLE) begin
      on_o[PIN_SPD]    = speed100_i;
      on_o[PIN_LNKACT] = act_busy_i ? act_lit_i : link_ok_i;
    end else begin
      on_o[PIN_SPD] = link_ok_i & speed100_i;
      on_o[PIN_TEN] = link_ok_i & ~speed100_i;
      on_o[PIN_ACT] = act_lit_i;
    end
  end
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int CLK_HZ = 25_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             led_mode_i,
  input  logic             link_ok_i,
  input  logic             speed100_i,
  input  logic             full_dup_i,
  input  logic             rx_act_i,
  input  logic             tx_act_i,
  input  logic             col_i,
  input  logic             pwr_down_i,
  input  logic [NPINS-1:0] strap_i,
  output logic [NPINS-1:0] led_o,
  output logic             led_oe_o,
  output logic [NPINS-1:0] phy_addr_o
);
  localparam int ACT_PERIOD = CLK_HZ / 10;
  localparam int COL_PERIOD = CLK_HZ / 20;

  led_mode_e        mode;
  logic             done, act_cond, col_cond;
  logic             act_busy, act_lit, col_busy, col_lit;
  logic [NPINS-1:0] pol, on;

  assign mode     = led_mode_e'(led_mode_i);
  // collision masks activity only in the three-LED layout
  assign act_cond = (rx_act_i | tx_act_i) & ((mode == MODE_QUAD) | ~col_i);
  assign col_cond = col_i & ~full_dup_i;

  led_strap_latch #(.W(NPINS)) u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i),
    .done_o(done), .pol_o(pol)
  );

  led_blinker #(.PERIOD(ACT_PERIOD), .STRETCH(1'b1)) u_act_blink (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(act_cond),
    .busy_o(act_busy), .lit_o(act_lit)
  );

  led_blinker #(.PERIOD(COL_PERIOD), .STRETCH(1'b0)) u_col_blink (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(col_cond),
    .busy_o(col_busy), .lit_o(col_lit)
  );

  led_pin_map u_map (
    .mode_i(mode), .link_ok_i(link_ok_i), .speed100_i(speed100_i),
    .full_dup_i(full_dup_i), .act_busy_i(act_busy), .act_lit_i(act_lit),
    .col_lit_i(col_lit), .on_o(on)
  );

  assign led_oe_o   = done & ~pwr_down_i;
  assign led_o      = led_oe_o ? (on ^ pol) : '0;
  assign phy_addr_o = pol;

  AST_QUAD_SPEED_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_oe_o && mode == MODE_QUAD) |-> $onehot0({led_o[PIN_SPD] ^ pol[PIN_SPD],
                                                  led_o[PIN_TEN] ^ pol[PIN_TEN]})); // R8
  AST_TRIPLE_SPARE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_oe_o && mode == MODE_TRIPLE) |-> (led_o[PIN_TEN:PIN_ACT] == pol[PIN_TEN:PIN_ACT])); // R9
  AST_DUPLEX_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_oe_o && full_dup_i) |-> (led_o[PIN_DUPCOL] != pol[PIN_DUPCOL])); // R6
  AST_COL_FD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_dup_i |=> !col_busy || !$past(full_dup_i)); // R6
endmodule

// File: tb/phy_led_ctrl_bench.sv
`timescale 1ns/1ps
module phy_led_ctrl_bench;
  localparam int CLK_HZ = 400;
  localparam int AP = CLK_HZ / 10;
  localparam int AH = AP / 2;
  localparam int CP = CLK_HZ / 20;
  localparam int CH = CP / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 0, link = 0, spd = 0, fd = 0, rx = 0, tx = 0, col = 0, pd = 0;
  logic [4:0] strap = 5'b10110;
  logic [4:0] led, addr;
  logic oe;

  int n_chk = 0, n_err = 0;
  bit checking = 0;

  always #2.5 clk = ~clk;

  phy_led_ctrl #(.CLK_HZ(CLK_HZ)) u_phy_led_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .led_mode_i(mode), .link_ok_i(link),
    .speed100_i(spd), .full_dup_i(fd), .rx_act_i(rx), .tx_act_i(tx),
    .col_i(col), .pwr_down_i(pd), .strap_i(strap),
    .led_o(led), .led_oe_o(oe), .phy_addr_o(addr)
  );

  // behavioural reference
  logic [4:0] m_pol;
  logic m_done;
  int act_pos, col_pos;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done <= 0; m_pol <= 0; act_pos <= -1; col_pos <= -1;
    end else begin
      bit ac, cc;
      if (!m_done) begin m_pol <= strap; m_done <= 1; end
      ac = (rx | tx) & (mode | ~col);
      if (act_pos < 0 || act_pos == AP - 1) act_pos <= ac ? 0 : -1;
      else act_pos <= act_pos + 1;
      cc = col & ~fd;
      if (!cc) col_pos <= -1;
      else if (col_pos < 0 || col_pos == CP - 1) col_pos <= 0;
      else col_pos <= col_pos + 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic string pin_tag(int i, bit m);
    if (i == 1) return "R6/R3";
    if (!m) return (i == 0) ? "R4/R3" : (i == 2) ? "R5/R7/R3" : "R9";
    return "R8/R7/R3";
  endfunction

  always @(negedge clk) if (checking) begin
    bit [4:0] e;
    bit a_lit, c_lit, e_oe;
    a_lit = act_pos >= 0 && act_pos < AH;
    c_lit = col_pos >= 0 && col_pos < CH;
    e = '0;
    e[1] = fd | c_lit;
    if (!mode) begin
      e[0] = spd;
      e[2] = (act_pos >= 0) ? a_lit : link;
    end else begin
      e[0] = link & spd;
      e[4] = link & ~spd;
      e[3] = a_lit;
    end
    e_oe = m_done & ~pd;
    chk(oe === e_oe, "R2 oe", oe, e_oe);
    if (!e_oe) chk(led === 5'b0, "R2 idle level", led, 0);
    else for (int i = 0; i < 5; i++)
      chk(led[i] === (e[i] ^ m_pol[i]), pin_tag(i, mode), led[i], e[i] ^ m_pol[i]);
    if (m_done) chk(addr === m_pol, "R1 addr", addr, m_pol);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_all();
    int lit_cnt;
    checking = 1;
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk(addr === 5'b10110, "R1 captured address", addr, 5'b10110);
    chk(led === 5'b10110, "R3 dark levels follow strap", led, 5'b10110);
    strap = 5'b01001;
    cyc(3);
    chk(addr === 5'b10110, "R1 address ignores later strap", addr, 5'b10110);
    // three-LED layout
    spd = 1; cyc(2);
    chk(led[0] === 1'b1, "R3/R4 active-high speed lamp", led[0], 1);
    link = 1; cyc(3);
    chk(led[2] === 1'b0, "R3/R5 active-low link lamp", led[2], 0);
    fd = 1; cyc(3);
    rx = 1; cyc(1); rx = 0;            // single pulse
    cyc(AP + 10);
    tx = 1; cyc(3 * AP + 7); tx = 0;
    cyc(AP);
    fd = 0; spd = 0;
    col = 1; tx = 1; cyc(2 * CP + 5);  // collision masks activity
    col = 0; cyc(3); col = 1; cyc(CP + 3); // restart on lit half
    fd = 1; cyc(CP);                   // full duplex masks collision
    col = 0; tx = 0; cyc(AP + 5);
    // four-LED layout
    mode = 1; cyc(AP + 2);
    tx = 1; cyc(1); tx = 0;
    lit_cnt = 0;
    for (int k = 0; k < 3 * AP; k++) begin
      @(negedge clk);
      if (led[3] ^ 1'b0) lit_cnt++;
    end
    chk(lit_cnt == AH, "R7 single pulse gives one lit half", lit_cnt, AH);
    #1;
    spd = 1; cyc(4); spd = 0; cyc(4); link = 0; cyc(4); link = 1;
    fd = 0; col = 1; rx = 1; cyc(2 * AP + 3); // collision does not mask activity here
    rx = 0; col = 0; cyc(AP + 3);
    pd = 1; cyc(10);
    chk(oe === 1'b0, "R2 power-down releases pads", oe, 0);
    pd = 0; cyc(5);
    // second reset, all straps low
    rst_n = 0; strap = 5'b00000; cyc(3);
    chk(oe === 1'b0, "R2 pads released in reset", oe, 0);
    rst_n = 1; cyc(1);
    chk(addr === 5'b00000, "R1 zero address", addr, 0);
    mode = 0; spd = 1; link = 1; fd = 0; col = 1; cyc(CP + 4);
    col = 0; rx = 1; cyc(AP); rx = 0; cyc(AP + 4);
    checking = 0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150_000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule